// File: doc/BRIEF.md
# Flash Array Program/Erase Sequencer

This block sits between a simple command port and the raw control pins of an embedded NOR-style flash array. A caller presents an operation code, a word address, write data and a one-cycle `start` strobe. The sequencer latches the command and drives the array enables, the program/erase strobes, the store strobe and the address and data buses through the phases that non-volatile storage needs. Each phase lasts a fixed number of clock cycles taken from parameters. A read returns data from the array's output bus. A program or erase ends with a recovery gap, and `done` then pulses once.

The word address splits into a row part (upper `ADDR_W-COL_W` bits, driven on `fa_xadr`) and a column part (low `COL_W` bits, driven on `fa_yadr`). One page is one row of `2**COL_W` words. The FSM has the states IDLE, READ, SETUP, PGSET, PULSE, PGHOLD, ERASE, NVHOLD and RECOVER. IDLE goes to READ on a read command and to SETUP on a program or erase command. READ goes back to IDLE. SETUP goes to PGSET for a program and to ERASE for an erase. PGSET goes to PULSE, PULSE to PGHOLD and PGHOLD to NVHOLD. ERASE goes to NVHOLD. NVHOLD goes to RECOVER, and RECOVER goes to IDLE. Every timed state leaves when its interval counter expires.

Top module: `flash_seq`

## Requirements
- R1: While the block is idle, and during reset, all eight array strobes (`fa_xe`, `fa_ye`, `fa_se`, `fa_oe`, `fa_prog`, `fa_erase`, `fa_mas`, `fa_nvstr`) and the outputs `busy`, `done` and `rvalid` are low.
- R2: A `start` with `op`=1 (read) drives `fa_xe`, `fa_ye`, `fa_se` and `fa_oe` high for exactly one cycle, with the other four strobes low. In the cycle two cycles after `start`, `rvalid` and `done` are both high, `busy` is low and `rdata` holds the word the array presented. There is no recovery gap.
- R3: A `start` with `op`=2 (program) gives the following sequence, with `fa_xe` high throughout. First `fa_prog` is high for T_NVS cycles. Then `fa_nvstr` rises, and T_PGS cycles later `fa_ye` is high for T_PROG cycles. `fa_prog` falls T_PGH cycles after `fa_ye` falls, and `fa_nvstr` falls T_NVH cycles after that. `fa_se`, `fa_oe`, `fa_erase` and `fa_mas` stay low.
- R4: During a read or a program, `fa_xadr` equals address bits [ADDR_W-1:COL_W], `fa_yadr` equals bits [COL_W-1:0] and `fa_din` equals the write data, all held stable while `fa_ye` is high.
- R5: A `start` with `op`=3 (page erase) gives the following sequence, with `fa_xe` high throughout. First `fa_erase` is high for T_NVS cycles. Then `fa_nvstr` joins it for T_ERASE cycles, and then `fa_erase` falls while `fa_nvstr` holds for T_NVH cycles. `fa_ye`, `fa_se`, `fa_oe`, `fa_prog` and `fa_mas` stay low.
- R6: A page erase drives `fa_yadr` to zero whatever the low COL_W address bits are, and drives the row part on `fa_xadr`.
- R7: A `start` with `op`=4 (mass erase) follows R5, except that `fa_mas` is high through every `fa_xe` phase, the erase phase lasts T_ME cycles and the store hold lasts T_NVH1 cycles.
- R8: After a program or erase, every strobe is low while `busy` stays high for T_RCV cycles. `done` is then high for exactly one cycle, with `busy` low.
- R9: A `start` while `busy` is high, or with `op` outside 1..4, has no effect on strobes, buses or timing.
- R10: A `start` presented in the same cycle that `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, sampled only when idle |
| op | input | 3 | Operation: 1 read, 2 program, 3 page erase, 4 mass erase |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Data word to program |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rvalid | output | 1 | Read data valid |
| rdata | output | DATA_W | Read data |
| fa_xe | output | 1 | Array row enable |
| fa_ye | output | 1 | Array column enable |
| fa_se | output | 1 | Array sense enable |
| fa_oe | output | 1 | Array output enable |
| fa_prog | output | 1 | Program strobe |
| fa_erase | output | 1 | Erase strobe |
| fa_mas | output | 1 | Whole-array select for erase |
| fa_nvstr | output | 1 | Non-volatile store strobe |
| fa_xadr | output | ADDR_W-COL_W | Row address to array |
| fa_yadr | output | COL_W | Column address to array |
| fa_din | output | DATA_W | Write data to array |
| fa_dout | input | DATA_W | Read data from array |

## Verification
Two functions can coincide in one cycle: the `done` pulse that ends a program, and the acceptance of the next command. The bench holds `start` high across the last recovery cycle and the `done` cycle. The earlier sample must be dropped because the block is busy, and the later one must be accepted. The scoreboard holds the full expected strobe pattern of both commands back to back, so any early or late acceptance shifts every following cycle and is reported.

// File: rtl/flash_seq_pkg.sv
`timescale 1ns/1ps
package flash_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_READ   = 3'd1,
        OP_PROG   = 3'd2,
        OP_PERASE = 3'd3,
        OP_MERASE = 3'd4
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_READ,
        S_SETUP,
        S_PGSET,
        S_PULSE,
        S_PGHOLD,
        S_ERASE,
        S_NVHOLD,
        S_RECOVER
    } state_e;

    typedef struct packed {
        logic xe;
        logic ye;
        logic se;
        logic oe;
        logic prog;
        logic erase;
        logic mas;
        logic nvstr;
    } strobe_t;

endpackage

// File: rtl/flash_seq_timer.sv
`timescale 1ns/1ps
module flash_seq_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/flash_seq_strobe.sv
`timescale 1ns/1ps
module flash_seq_strobe
    import flash_seq_pkg::*;
(
    input  state_e  state,
    input  logic    is_erase,
    input  logic    is_mass,
    output strobe_t stb
);
    always_comb begin
        stb = '0;
        unique case (state)
            S_IDLE: ;
            S_READ: begin
                stb.xe = 1'b1;
                stb.ye = 1'b1;
                stb.se = 1'b1;
                stb.oe = 1'b1;
            end
            S_SETUP: begin
                stb.xe    = 1'b1;
                stb.prog  = !is_erase;
                stb.erase = is_erase;
                stb.mas   = is_mass;
            end
            S_PGSET, S_PGHOLD: begin
                stb.xe    = 1'b1;
                stb.prog  = 1'b1;
                stb.nvstr = 1'b1;
            end
            S_PULSE: begin
                stb.xe    = 1'b1;
                stb.ye    = 1'b1;
                stb.prog  = 1'b1;
                stb.nvstr = 1'b1;
            end
            S_ERASE: begin
                stb.xe    = 1'b1;
                stb.erase = 1'b1;
                stb.nvstr = 1'b1;
                stb.mas   = is_mass;
            end
            S_NVHOLD: begin
                stb.xe    = 1'b1;
                stb.nvstr = 1'b1;
                stb.mas   = is_mass;
            end
            S_RECOVER: ;
            default: stb = '0;
        endcase
    end
endmodule

// File: rtl/flash_seq.sv
`timescale 1ns/1ps
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int COL_W   = 8,
    parameter int DATA_W  = 16,
    parameter int T_NVS   = 3,
    parameter int T_PGS   = 2,
    parameter int T_PROG  = 5,
    parameter int T_PGH   = 2,
    parameter int T_NVH   = 3,
    parameter int T_NVH1  = 4,
    parameter int T_ERASE = 6,
    parameter int T_ME    = 8,
    parameter int T_RCV   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              op,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic                    busy,
    output logic                    done,
    output logic                    rvalid,
    output logic [DATA_W-1:0]       rdata,
    output logic                    fa_xe,
    output logic                    fa_ye,
    output logic                    fa_se,
    output logic                    fa_oe,
    output logic                    fa_prog,
    output logic                    fa_erase,
    output logic                    fa_mas,
    output logic                    fa_nvstr,
    output logic [ADDR_W-COL_W-1:0] fa_xadr,
    output logic [COL_W-1:0]        fa_yadr,
    output logic [DATA_W-1:0]       fa_din,
    input  logic [DATA_W-1:0]       fa_dout
);
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int T_MAX = imax(imax(imax(T_NVS, T_PGS), imax(T_PROG, T_PGH)),
                                imax(imax(T_NVH, T_NVH1), imax(imax(T_ERASE, T_ME), T_RCV)));
    localparam int CW = $clog2(T_MAX + 1);

    localparam logic [CW-1:0] L_NVS   = CW'(T_NVS - 1);
    localparam logic [CW-1:0] L_PGS   = CW'(T_PGS - 1);
    localparam logic [CW-1:0] L_PROG  = CW'(T_PROG - 1);
    localparam logic [CW-1:0] L_PGH   = CW'(T_PGH - 1);
    localparam logic [CW-1:0] L_NVH   = CW'(T_NVH - 1);
    localparam logic [CW-1:0] L_NVH1  = CW'(T_NVH1 - 1);
    localparam logic [CW-1:0] L_ERASE = CW'(T_ERASE - 1);
    localparam logic [CW-1:0] L_ME    = CW'(T_ME - 1);
    localparam logic [CW-1:0] L_RCV   = CW'(T_RCV - 1);

    state_e              state, nxt;
    op_e                 op_in, op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                rvalid_q, done_q;
    logic                expired, ld;
    logic [CW-1:0]       ld_val;
    logic                is_erase, is_mass, accept;
    strobe_t             stb;

    assign op_in    = op_e'(op);
    assign is_mass  = (op_q == OP_MERASE);
    assign is_erase = (op_q == OP_PERASE) || is_mass;
    assign accept   = (state == S_IDLE) && (nxt != S_IDLE);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    case (op_in)
                        OP_READ:                      nxt = S_READ;
                        OP_PROG, OP_PERASE, OP_MERASE: nxt = S_SETUP;
                        default:                      nxt = S_IDLE;
                    endcase
                end
            end
            S_READ:    nxt = S_IDLE;
            S_SETUP:   if (expired) nxt = is_erase ? S_ERASE : S_PGSET;
            S_PGSET:   if (expired) nxt = S_PULSE;
            S_PULSE:   if (expired) nxt = S_PGHOLD;
            S_PGHOLD:  if (expired) nxt = S_NVHOLD;
            S_ERASE:   if (expired) nxt = S_NVHOLD;
            S_NVHOLD:  if (expired) nxt = S_RECOVER;
            S_RECOVER: if (expired) nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    always_comb begin
        ld     = (nxt != state);
        ld_val = '0;
        unique case (nxt)
            S_SETUP:   ld_val = L_NVS;
            S_PGSET:   ld_val = L_PGS;
            S_PULSE:   ld_val = L_PROG;
            S_PGHOLD:  ld_val = L_PGH;
            S_ERASE:   ld_val = is_mass ? L_ME : L_ERASE;
            S_NVHOLD:  ld_val = is_mass ? L_NVH1 : L_NVH;
            S_RECOVER: ld_val = L_RCV;
            S_IDLE, S_READ: ld_val = '0;
            default:   ld_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_NONE;
            addr_q   <= '0;
            data_q   <= '0;
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (accept) begin
                op_q   <= op_in;
                addr_q <= addr;
                data_q <= wdata;
            end
            if (state == S_READ) begin
                rdata_q <= fa_dout;
            end
            rvalid_q <= (state == S_READ);
            done_q   <= (state == S_READ) || ((state == S_RECOVER) && expired);
        end
    end

    flash_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    flash_seq_strobe u_strobe (
        .state    (state),
        .is_erase (is_erase),
        .is_mass  (is_mass),
        .stb      (stb)
    );

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign rvalid   = rvalid_q;
    assign rdata    = rdata_q;
    assign fa_xe    = stb.xe;
    assign fa_ye    = stb.ye;
    assign fa_se    = stb.se;
    assign fa_oe    = stb.oe;
    assign fa_prog  = stb.prog;
    assign fa_erase = stb.erase;
    assign fa_mas   = stb.mas;
    assign fa_nvstr = stb.nvstr;
    assign fa_xadr  = addr_q[ADDR_W-1:COL_W];
    assign fa_yadr  = is_erase ? '0 : addr_q[COL_W-1:0];
    assign fa_din   = data_q;
endmodule

// File: rtl/flash_seq_chk.sv
`timescale 1ns/1ps
module flash_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    busy,
    input logic                    done,
    input logic                    rvalid,
    input logic                    fa_xe,
    input logic                    fa_ye,
    input logic                    fa_se,
    input logic                    fa_oe,
    input logic                    fa_prog,
    input logic                    fa_erase,
    input logic                    fa_mas,
    input logic                    fa_nvstr,
    input logic [ADDR_W-COL_W-1:0] fa_xadr,
    input logic [COL_W-1:0]        fa_yadr,
    input logic [DATA_W-1:0]       fa_din
);
    logic [7:0] stbv;
    assign stbv = {fa_xe, fa_ye, fa_se, fa_oe, fa_prog, fa_erase, fa_mas, fa_nvstr};

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (stbv == 8'h00));

    p_rvalid_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (done && !busy));

    p_nvstr_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fa_nvstr) |-> $past(fa_prog || fa_erase) && (fa_prog || fa_erase));

    p_nvstr_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fa_nvstr) |-> !fa_prog && !fa_erase && $past(!fa_prog && !fa_erase));

    p_ye_inside_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_ye && !fa_oe) |-> (fa_prog && fa_nvstr && fa_xe));

    p_bus_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fa_ye && !fa_oe && $past(fa_ye && !fa_oe)) |->
            ($stable(fa_xadr) && $stable(fa_yadr) && $stable(fa_din)));

    p_erase_col_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fa_erase |-> (fa_yadr == '0));

    p_mas_erase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fa_mas |-> (fa_xe && !fa_prog && !fa_ye));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind flash_seq flash_seq_chk #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W)
) u_chk (.*);

// File: tb/flash_seq_tb.sv
`timescale 1ns/1ps
module flash_seq_tb;
    localparam int ADDR_W = 12, COL_W = 8, DATA_W = 16, ROW_W = ADDR_W - COL_W;
    localparam int T_NVS = 3, T_PGS = 2, T_PROG = 5, T_PGH = 2, T_NVH = 3;
    localparam int T_NVH1 = 4, T_ERASE = 6, T_ME = 8, T_RCV = 3;

    localparam logic [7:0] B_XE = 8'h80, B_YE = 8'h40, B_SE = 8'h20, B_OE = 8'h10;
    localparam logic [7:0] B_PG = 8'h08, B_ER = 8'h04, B_MS = 8'h02, B_NV = 8'h01;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              rvalid;
        logic [7:0]        stb;
        logic              chk_bus;
        logic [ROW_W-1:0]  xadr;
        logic [COL_W-1:0]  yadr;
        logic [DATA_W-1:0] din;
        logic              chk_rd;
        logic [DATA_W-1:0] rd;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, start;
    logic [2:0] op_i;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] wdata_i;
    logic busy, done, rvalid;
    logic [DATA_W-1:0] rdata;
    logic fa_xe, fa_ye, fa_se, fa_oe, fa_prog, fa_erase, fa_mas, fa_nvstr;
    logic [ROW_W-1:0] fa_xadr;
    logic [COL_W-1:0] fa_yadr;
    logic [DATA_W-1:0] fa_din, fa_dout;

    function automatic logic [DATA_W-1:0] model(input logic [ROW_W-1:0] x, input logic [COL_W-1:0] y);
        return {4'h5, x, y} ^ 16'h3C69;
    endfunction
    assign fa_dout = model(fa_xadr, fa_yadr);

    flash_seq #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_NVS(T_NVS), .T_PGS(T_PGS), .T_PROG(T_PROG), .T_PGH(T_PGH),
        .T_NVH(T_NVH), .T_NVH1(T_NVH1), .T_ERASE(T_ERASE), .T_ME(T_ME), .T_RCV(T_RCV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op_i), .addr(addr_i), .wdata(wdata_i),
        .busy(busy), .done(done), .rvalid(rvalid), .rdata(rdata),
        .fa_xe(fa_xe), .fa_ye(fa_ye), .fa_se(fa_se), .fa_oe(fa_oe),
        .fa_prog(fa_prog), .fa_erase(fa_erase), .fa_mas(fa_mas), .fa_nvstr(fa_nvstr),
        .fa_xadr(fa_xadr), .fa_yadr(fa_yadr), .fa_din(fa_din), .fa_dout(fa_dout)
    );

    exp_t  q[$];
    string qtag[$];
    string ctx = "";
    int    checks = 0;
    int    bad = 0;
    logic  mon_on = 1'b0;

    function automatic logic [7:0] act_stb();
        return {fa_xe, fa_ye, fa_se, fa_oe, fa_prog, fa_erase, fa_mas, fa_nvstr};
    endfunction

    task automatic put(input logic b, input logic d, input logic rv, input logic [7:0] s,
                       input logic cb, input logic [ROW_W-1:0] x, input logic [COL_W-1:0] y,
                       input logic [DATA_W-1:0] dn, input logic cr, input logic [DATA_W-1:0] rd,
                       input string tag, input int n);
        exp_t e;
        e = '{busy:b, done:d, rvalid:rv, stb:s, chk_bus:cb, xadr:x, yadr:y, din:dn, chk_rd:cr, rd:rd};
        for (int i = 0; i < n; i++) begin
            q.push_back(e);
            qtag.push_back(tag);
        end
    endtask

    // Expected cycle-by-cycle trace of one accepted command
    task automatic expect_cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic [ROW_W-1:0] x;
        logic [COL_W-1:0] y;
        logic [7:0] m;
        x = a[ADDR_W-1:COL_W];
        y = a[COL_W-1:0];
        case (op)
            3'd1: begin
                put(1, 0, 0, B_XE|B_YE|B_SE|B_OE, 1, x, y, d, 0, '0, "R2 read strobes", 1);
                put(0, 1, 1, 8'h00, 0, '0, '0, '0, 1, model(x, y), "R2 read data", 1);
            end
            3'd2: begin
                put(1, 0, 0, B_XE|B_PG, 1, x, y, d, 0, '0, "R3 prog setup", T_NVS);
                put(1, 0, 0, B_XE|B_PG|B_NV, 1, x, y, d, 0, '0, "R3 store setup", T_PGS);
                put(1, 0, 0, B_XE|B_YE|B_PG|B_NV, 1, x, y, d, 0, '0, "R4 prog pulse", T_PROG);
                put(1, 0, 0, B_XE|B_PG|B_NV, 1, x, y, d, 0, '0, "R3 prog hold", T_PGH);
                put(1, 0, 0, B_XE|B_NV, 1, x, y, d, 0, '0, "R3 store hold", T_NVH);
                put(1, 0, 0, 8'h00, 0, '0, '0, '0, 0, '0, "R8 recovery", T_RCV);
                put(0, 1, 0, 8'h00, 0, '0, '0, '0, 0, '0, "R8 done", 1);
            end
            3'd3, 3'd4: begin
                m = (op == 3'd4) ? B_MS : 8'h00;
                put(1, 0, 0, B_XE|B_ER|m, 1, x, '0, d, 0, '0, (op == 3'd4) ? "R7 setup" : "R5 setup", T_NVS);
                put(1, 0, 0, B_XE|B_ER|B_NV|m, 1, x, '0, d, 0, '0, (op == 3'd4) ? "R7 erase" : "R6 erase",
                    (op == 3'd4) ? T_ME : T_ERASE);
                put(1, 0, 0, B_XE|B_NV|m, 1, x, '0, d, 0, '0, (op == 3'd4) ? "R7 hold" : "R5 hold",
                    (op == 3'd4) ? T_NVH1 : T_NVH);
                put(1, 0, 0, 8'h00, 0, '0, '0, '0, 0, '0, "R8 recovery", T_RCV);
                put(0, 1, 0, 8'h00, 0, '0, '0, '0, 0, '0, "R8 done", 1);
            end
            default: ;
        endcase
    endtask

    task automatic drive(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        start = 1'b1; op_i = op; addr_i = a; wdata_i = d;
        expect_cmd(op, a, d);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
    endtask

    // Monitor: compares every cycle against the scoreboard, or the idle state
    initial begin
        exp_t  e;
        string t;
        wait (mon_on);
        forever begin
            @(posedge clk);
            #2;
            checks++;
            if (q.size() > 0) begin
                e = q.pop_front();
                t = qtag.pop_front();
                if (busy !== e.busy || done !== e.done || rvalid !== e.rvalid || act_stb() !== e.stb ||
                    (e.chk_bus && (fa_xadr !== e.xadr || fa_yadr !== e.yadr || fa_din !== e.din)) ||
                    (e.chk_rd && rdata !== e.rd)) begin
                    bad++;
                    $display("FAIL %s %s: act b=%b d=%b v=%b s=%h x=%h y=%h din=%h rd=%h exp b=%b d=%b v=%b s=%h x=%h y=%h din=%h rd=%h",
                             t, ctx, busy, done, rvalid, act_stb(), fa_xadr, fa_yadr, fa_din, rdata,
                             e.busy, e.done, e.rvalid, e.stb, e.xadr, e.yadr, e.din, e.rd);
                end
            end else begin
                if (busy !== 1'b0 || done !== 1'b0 || rvalid !== 1'b0 || act_stb() !== 8'h00) begin
                    bad++;
                    $display("FAIL R1/R9 idle %s: act b=%b d=%b v=%b s=%h exp b=0 d=0 v=0 s=00",
                             ctx, busy, done, rvalid, act_stb());
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog: act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; op_i = '0; addr_i = '0; wdata_i = '0;
        repeat (3) @(negedge clk);
        checks++;
        if (busy !== 1'b0 || done !== 1'b0 || rvalid !== 1'b0 || act_stb() !== 8'h00) begin
            bad++;
            $display("FAIL R1 reset: act b=%b d=%b v=%b s=%h exp all zero", busy, done, rvalid, act_stb());
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (2) @(negedge clk);

        ctx = "R2 reads";
        drive(3'd1, 12'h3A7, 16'h0000);
        repeat (2) @(negedge clk);
        drive(3'd1, 12'hFFF, 16'h0000);
        wait_idle();

        ctx = "R3 R4 program";
        drive(3'd2, 12'h512, 16'hBEEF);
        wait_idle();

        ctx = "R5 R6 page erase";
        drive(3'd3, 12'h7C5, 16'h1234);
        wait_idle();

        ctx = "R7 mass erase";
        drive(3'd4, 12'h0AB, 16'h0000);
        wait_idle();

        ctx = "R9 bad op codes";
        drive(3'd0, 12'h111, 16'h1111);
        drive(3'd7, 12'h222, 16'h2222);
        drive(3'd5, 12'h333, 16'h3333);
        wait_idle();

        ctx = "R9 start while busy";
        drive(3'd2, 12'hA0F, 16'h55AA);
        repeat (4) @(negedge clk);
        start = 1'b1; op_i = 3'd1; addr_i = 12'h001; wdata_i = 16'hFFFF;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        ctx = "R10 start with done";
        drive(3'd2, 12'h6C3, 16'hC0DE);
        repeat (T_NVS + T_PGS + T_PROG + T_PGH + T_NVH + T_RCV - 1) @(negedge clk);
        start = 1'b1; op_i = 3'd3; addr_i = 12'h9E1; wdata_i = 16'h0F0F;
        @(negedge clk);
        expect_cmd(3'd3, 12'h9E1, 16'h0F0F);
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        ctx = "R2 read after erase";
        drive(3'd1, 12'h0FE, 16'h0000);
        wait_idle();

        summary();
        $finish;
    end
endmodule